// File: doc/BRIEF.md
# Manchester Line Transmitter with Preamble

This block turns characters into a Manchester-coded serial line. A producer hands over one word at a time, together with a flag that says whether the word is a sync field or an ordinary data character. The transfer uses a valid/ready handshake. A single-cycle `half_tick` strobe, made elsewhere, paces the line: each strobe moves the line on by one half-bit period.

Every frame goes out in a fixed order. First comes a preamble of 0 to 15 bit periods in one of four patterns. Next comes a start delimiter. Last come the data bits, least significant first. The delimiter is either one coded logic 1, or a 3-bit-period pattern that deliberately breaks the coding rules. That second form holds the line at one level for three half-bits and then at the other level for three half-bits. Which level comes first tells a receiver whether the word is a sync field or a data character.

A polarity input inverts every level of the frame. Between frames the line rests at the level that ends a coded logic 1. The settings and the word are captured when the handshake completes, so the producer may change them while a frame is on the line.

Top module: `manch_tx`

## Requirements
- R1: `in_ready` is high exactly while no frame is in progress, and is high during reset. A word is taken on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is low from the next cycle.
- R2: While no frame is in progress, the clock edge after each cycle sets `line_out` to the current `cfg_invert`. This is the level that follows a coded logic 1. During reset `line_out` is 0.
- R3: During a frame, `line_out` changes only on clock edges where `half_tick` is high, and each such edge emits exactly one half-bit.
- R4: With `cfg_invert` = 0, a logic 0 is sent as low then high and a logic 1 as high then low. With `cfg_invert` = 1, every frame half-bit, including the preamble and delimiter, is inverted.
- R5: `cfg_pre_len` (0 to 15) sets the preamble length in bit periods. A value of 0 sends no preamble, so the delimiter starts on the first strobe.
- R6: `cfg_pre_pat` selects the preamble bits: 0 gives all ones, 1 gives all zeros, 2 gives 0,1,0,1… and 3 gives 1,0,1,0… Each preamble bit is Manchester coded.
- R7: With `cfg_sync_delim` = 0, the delimiter is a single coded logic 1 (two half-bits), and `in_sync` has no effect on the line.
- R8: With `cfg_sync_delim` = 1, the delimiter is six half-bits. Before inversion it is high, high, high, low, low, low for a sync word (`in_sync` = 1) and low, low, low, high, high, high for a data word.
- R9: The `DATA_W` data bits follow the delimiter, least significant bit first, each Manchester coded.
- R10: The word, the sync flag, preamble length, pattern, polarity and delimiter style are sampled at acceptance. Changing them later does not change that frame's half-bits.
- R11: The last data half-bit lasts one full strobe period. On the next strobe edge `line_out` takes the idle level and `in_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tick | input | 1 | One-cycle strobe per half-bit period |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | Transmitter is idle and takes a word |
| in_data | input | DATA_W | Character to send |
| in_sync | input | 1 | Word is a sync field (1) or data character (0) |
| cfg_pre_len | input | 4 | Preamble length in bit periods |
| cfg_pre_pat | input | 2 | Preamble pattern code |
| cfg_invert | input | 1 | Invert the coding polarity |
| cfg_sync_delim | input | 1 | 1 selects the 3-bit-period delimiter, 0 the one-bit delimiter |
| line_out | output | 1 | Coded serial line |

## Verification
The assertions check the timing skeleton on every cycle. They cover the handshake, the line holding still between strobes within a frame, and the idle level following the polarity input. They also check that `in_ready` only rises on a strobe edge. The bit-level content cannot be seen by a per-cycle property, because it depends on the captured word and settings. That content is the preamble patterns and lengths, both delimiter forms and orders, the data bit order, polarity inversion and the snapshot at acceptance. Only the bench's scenarios show it, by comparing each half-bit against a frame the model builds from the requirements.

// File: rtl/manch_tx_pkg.sv
package manch_tx_pkg;

  localparam int unsigned PRE_W = 4;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PRE   = 3'd1,
    PH_DELIM = 3'd2,
    PH_DATA  = 3'd3,
    PH_TAIL  = 3'd4
  } phase_e;

  // Level of one half of a coded bit, before polarity: 0 -> low,high ; 1 -> high,low
  function automatic logic manch_half(input logic bitval, input logic second);
    return bitval ^ second;
  endfunction

endpackage

// File: rtl/manch_tx_rsync.sv
module manch_tx_rsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/manch_tx_seq.sv
module manch_tx_seq
  import manch_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 half_tick,
  input  logic                 in_valid,
  input  logic [DATA_W-1:0]    in_data,
  input  logic                 in_sync,
  input  logic [PRE_W-1:0]     cfg_pre_len,
  input  logic [1:0]           cfg_pre_pat,
  input  logic                 cfg_invert,
  input  logic                 cfg_sync_delim,
  output logic                 in_ready,
  output phase_e               phase,
  output logic [IDX_W-1:0]     idx,
  output logic                 half_sel,
  output logic [DATA_W-1:0]    word,
  output logic                 fr_sync,
  output logic [1:0]           fr_pat,
  output logic                 fr_inv,
  output logic                 fr_sdelim
);
  phase_e             ph_q, ph_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               half_q, half_d;
  logic               cap_en;

  logic [PRE_W-1:0]   len_q;
  logic [1:0]         pat_q;
  logic               inv_q, sdelim_q, sync_q;
  logic [DATA_W-1:0]  word_q;

  logic [IDX_W-1:0]   pre_last, delim_last;

  assign pre_last   = IDX_W'(len_q) - IDX_W'(1);
  assign delim_last = sdelim_q ? IDX_W'(5) : IDX_W'(1);

  // next-state
  always_comb begin
    ph_d   = ph_q;
    idx_d  = idx_q;
    half_d = half_q;
    cap_en = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (in_valid) begin
          cap_en = 1'b1;
          ph_d   = (cfg_pre_len != '0) ? PH_PRE : PH_DELIM;
          idx_d  = '0;
          half_d = 1'b0;
        end
      end
      PH_PRE: begin
        if (half_tick) begin
          half_d = ~half_q;
          if (half_q) begin
            if (idx_q == pre_last) begin
              ph_d  = PH_DELIM;
              idx_d = '0;
            end else begin
              idx_d = idx_q + IDX_W'(1);
            end
          end
        end
      end
      PH_DELIM: begin
        if (half_tick) begin
          if (idx_q == delim_last) begin
            ph_d   = PH_DATA;
            idx_d  = '0;
            half_d = 1'b0;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      PH_DATA: begin
        if (half_tick) begin
          half_d = ~half_q;
          if (half_q) begin
            if (idx_q == IDX_W'(DATA_W - 1)) ph_d = PH_TAIL;
            else                             idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      PH_TAIL: begin
        if (half_tick) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      idx_q  <= '0;
      half_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      half_q <= half_d;
    end
  end

  // frame snapshot, enabled on acceptance only
  always_ff @(posedge clk) begin
    if (cap_en) begin
      len_q    <= cfg_pre_len;
      pat_q    <= cfg_pre_pat;
      inv_q    <= cfg_invert;
      sdelim_q <= cfg_sync_delim;
      sync_q   <= in_sync;
      word_q   <= in_data;
    end
  end

  assign in_ready  = (ph_q == PH_IDLE);
  assign phase     = ph_q;
  assign idx       = idx_q;
  assign half_sel  = half_q;
  assign word      = word_q;
  assign fr_sync   = sync_q;
  assign fr_pat    = pat_q;
  assign fr_inv    = inv_q;
  assign fr_sdelim = sdelim_q;
endmodule

// File: rtl/manch_tx_sym.sv
module manch_tx_sym
  import manch_tx_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned IDX_W     = 4,
  parameter bit          LSB_FIRST = 1'b1
) (
  input  phase_e              phase,
  input  logic [IDX_W-1:0]    idx,
  input  logic                half_sel,
  input  logic [DATA_W-1:0]   word,
  input  logic                fr_sync,
  input  logic [1:0]          fr_pat,
  input  logic                fr_inv,
  input  logic                fr_sdelim,
  output logic                level
);
  localparam int unsigned DW_IDX = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DW_IDX-1:0] didx;
  logic              data_bit;
  logic              pre_bit;
  logic              raw;

  assign didx = idx[DW_IDX-1:0];

  if (LSB_FIRST) begin : g_lsb_first
    assign data_bit = word[didx];
  end else begin : g_msb_first
    assign data_bit = word[DW_IDX'(DATA_W - 1) - didx];
  end

  always_comb begin
    case (fr_pat)
      2'd0:    pre_bit = 1'b1;
      2'd1:    pre_bit = 1'b0;
      2'd2:    pre_bit = idx[0];
      default: pre_bit = ~idx[0];
    endcase
  end

  always_comb begin
    case (phase)
      PH_PRE:   raw = manch_half(pre_bit, half_sel);
      PH_DELIM: begin
        if (fr_sdelim) raw = (idx < IDX_W'(3)) ? fr_sync : ~fr_sync;
        else           raw = manch_half(1'b1, idx[0]);
      end
      PH_DATA:  raw = manch_half(data_bit, half_sel);
      default:  raw = 1'b0;
    endcase
  end

  assign level = raw ^ fr_inv;
endmodule

// File: rtl/manch_tx.sv
module manch_tx
  import manch_tx_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter bit          LSB_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sync,
  input  logic [3:0]        cfg_pre_len,
  input  logic [1:0]        cfg_pre_pat,
  input  logic              cfg_invert,
  input  logic              cfg_sync_delim,
  output logic              line_out
);
  localparam int unsigned CNT_SPAN = (DATA_W > 16) ? DATA_W : 16;
  localparam int unsigned IDX_W    = $clog2(CNT_SPAN);

  logic              rst_n_int;
  phase_e            phase;
  logic [IDX_W-1:0]  idx;
  logic              half_sel;
  logic [DATA_W-1:0] word;
  logic              fr_sync, fr_inv, fr_sdelim;
  logic [1:0]        fr_pat;
  logic              sym_level;
  logic              line_q, line_d;

  manch_tx_rsync u_rsync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_out (rst_n_int)
  );

  manch_tx_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .half_tick      (half_tick),
    .in_valid       (in_valid),
    .in_data        (in_data),
    .in_sync        (in_sync),
    .cfg_pre_len    (cfg_pre_len),
    .cfg_pre_pat    (cfg_pre_pat),
    .cfg_invert     (cfg_invert),
    .cfg_sync_delim (cfg_sync_delim),
    .in_ready       (in_ready),
    .phase          (phase),
    .idx            (idx),
    .half_sel       (half_sel),
    .word           (word),
    .fr_sync        (fr_sync),
    .fr_pat         (fr_pat),
    .fr_inv         (fr_inv),
    .fr_sdelim      (fr_sdelim)
  );

  manch_tx_sym #(.DATA_W(DATA_W), .IDX_W(IDX_W), .LSB_FIRST(LSB_FIRST)) u_sym (
    .phase     (phase),
    .idx       (idx),
    .half_sel  (half_sel),
    .word      (word),
    .fr_sync   (fr_sync),
    .fr_pat    (fr_pat),
    .fr_inv    (fr_inv),
    .fr_sdelim (fr_sdelim),
    .level     (sym_level)
  );

  // line next-state: idle follows live polarity, frame moves on strobes
  always_comb begin
    line_d = line_q;
    if (phase == PH_IDLE) begin
      line_d = cfg_invert;
    end else if (half_tick) begin
      line_d = (phase == PH_TAIL) ? cfg_invert : sym_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) line_q <= 1'b0;
    else            line_q <= line_d;
  end

  assign line_out = line_q;
endmodule

// File: rtl/manch_tx_chk.sv
module manch_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic half_tick,
  input logic in_valid,
  input logic in_ready,
  input logic cfg_invert,
  input logic line_out
);
  // R1: an accepted word makes the block busy on the next cycle
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R1: a busy block stays busy without a strobe
  p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !half_tick) |=> !in_ready);

  // R2: idle line tracks the polarity input
  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> (line_out == $past(cfg_invert)));

  // R3: within a frame the line holds between strobes
  p_line_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !half_tick) |=> $stable(line_out));

  // R11: the block only returns to idle on a strobe edge
  p_ready_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(half_tick));
endmodule

bind manch_tx manch_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .half_tick  (half_tick),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .cfg_invert (cfg_invert),
  .line_out   (line_out)
);

// File: tb/manch_tx_tb.sv
`timescale 1ns/1ps
module manch_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_sync = 1'b0;
  logic [3:0] cfg_pre_len = 4'd0;
  logic [1:0] cfg_pre_pat = 2'd0;
  logic       cfg_invert = 1'b0;
  logic       cfg_sync_delim = 1'b0;
  logic       line_out;

  int checks = 0;
  int errors = 0;
  int tick_per = 2;
  int tick_ph = 0;
  string cur_tag = "R2";

  // reference model state
  bit m_busy = 0;
  bit accepted = 0;
  bit exp_line = 0;
  bit exp_ready = 1;
  bit q[$];

  always #5 clk = ~clk;

  manch_tx u_dut (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sync(in_sync),
    .cfg_pre_len(cfg_pre_len), .cfg_pre_pat(cfg_pre_pat), .cfg_invert(cfg_invert),
    .cfg_sync_delim(cfg_sync_delim), .line_out(line_out)
  );

  task automatic push_bit(input bit b, input bit inv);
    q.push_back(b ^ inv);       // first half: 1 -> high, 0 -> low (R4)
    q.push_back((!b) ^ inv);    // second half is the complement
  endtask

  // Build the expected half-bit list from the requirements
  task automatic build_frame();
    q.delete();
    for (int i = 0; i < cfg_pre_len; i++) begin
      bit pb;
      case (cfg_pre_pat)
        2'd0: pb = 1;
        2'd1: pb = 0;
        2'd2: pb = (i % 2) == 1;
        default: pb = (i % 2) == 0;
      endcase
      push_bit(pb, cfg_invert);
    end
    if (!cfg_sync_delim) push_bit(1'b1, cfg_invert);
    else begin
      for (int k = 0; k < 6; k++) q.push_back(((k < 3) ? in_sync : !in_sync) ^ cfg_invert);
    end
    for (int i = 0; i < 8; i++) push_bit(in_data[i], cfg_invert);
  endtask

  task automatic model_step();
    accepted = 0;
    if (!m_busy) begin
      exp_line = cfg_invert;
      if (in_valid) begin
        build_frame();
        m_busy = 1;
        accepted = 1;
      end
    end else if (half_tick) begin
      if (q.size() > 0) exp_line = q.pop_front();
      else begin
        m_busy = 0;
        exp_line = cfg_invert;
      end
    end
    exp_ready = !m_busy;
  endtask

  task automatic compare();
    checks++;
    if (line_out !== exp_line) begin
      errors++;
      $display("FAIL %s line_out=%0b expected=%0b at %0t", cur_tag, line_out, exp_line, $time);
    end
    checks++;
    if (in_ready !== exp_ready) begin
      errors++;
      $display("FAIL R1 R11 (%s) in_ready=%0b expected=%0b at %0t", cur_tag, in_ready, exp_ready, $time);
    end
  endtask

  task automatic cycle();
    half_tick = (tick_ph == 0);
    tick_ph = (tick_ph + 1) % tick_per;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic send(input bit [3:0] len, input bit [1:0] pat, input bit inv,
                      input bit sd, input bit sy, input bit [7:0] d,
                      input bit scramble, input string tag);
    cur_tag = tag;
    cfg_pre_len = len; cfg_pre_pat = pat; cfg_invert = inv;
    cfg_sync_delim = sd; in_sync = sy; in_data = d;
    in_valid = 1'b1;
    do cycle(); while (!accepted);
    in_valid = 1'b0;
    if (scramble) begin
      // R10: everything changes after acceptance; the frame must not
      cfg_pre_len = ~len; cfg_pre_pat = ~pat; cfg_sync_delim = ~sd;
      in_sync = ~sy; in_data = ~d;
    end
    while (m_busy) cycle();
    repeat (3) cycle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 R2: reset state
    repeat (2) @(negedge clk);
    checks++;
    if (line_out !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 R2 reset line_out=%0b in_ready=%0b expected=0 1", line_out, in_ready);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: idle level follows polarity
    cur_tag = "R2";
    repeat (3) cycle();
    cfg_invert = 1'b1; repeat (3) cycle();
    cfg_invert = 1'b0; repeat (3) cycle();

    // R4 R9: basic frame, both polarities
    send(4'd4, 2'd0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, "R4 R9");
    send(4'd3, 2'd0, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b0, "R4 R9 inverted");

    // R6: each preamble pattern
    send(4'd5, 2'd1, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0, "R6 zeros");
    send(4'd5, 2'd2, 1'b0, 1'b0, 1'b0, 8'h80, 1'b0, "R6 alt0");
    send(4'd6, 2'd3, 1'b1, 1'b0, 1'b0, 8'hF0, 1'b0, "R6 alt1");

    // R5: length boundaries
    send(4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b0, "R5 len0");
    send(4'd15, 2'd2, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, "R5 len15");

    // R7: one-bit delimiter ignores the sync flag
    send(4'd2, 2'd0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, "R7");

    // R8: sync-pattern delimiter, sync and data words, both polarities
    send(4'd2, 2'd0, 1'b0, 1'b1, 1'b1, 8'h96, 1'b0, "R8 sync");
    send(4'd2, 2'd0, 1'b0, 1'b1, 1'b0, 8'h69, 1'b0, "R8 data");
    send(4'd1, 2'd3, 1'b1, 1'b1, 1'b1, 8'h0F, 1'b0, "R8 sync inv");

    // R10: settings and word change mid-frame
    send(4'd3, 2'd2, 1'b0, 1'b0, 1'b1, 8'hC3, 1'b1, "R10");
    send(4'd2, 2'd1, 1'b1, 1'b1, 1'b0, 8'h24, 1'b1, "R10 b");

    // R3 R11: slow and every-cycle strobes
    tick_per = 3;
    send(4'd2, 2'd3, 1'b0, 1'b1, 1'b0, 8'hB7, 1'b0, "R3 R11 slow");
    tick_per = 1;
    send(4'd1, 2'd0, 1'b1, 1'b0, 1'b0, 8'h4E, 1'b0, "R3 R11 fast");
    tick_per = 5;
    send(4'd0, 2'd0, 1'b0, 1'b1, 1'b1, 8'hD2, 1'b0, "R3 R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule